// File: doc/BRIEF.md
# Dual-Channel SAR ADC Readout Controller

This controller sits on the host side of a two-channel successive-approximation converter that samples both channels at the same moment. On a start request it drives the active-low conversion strobe low for a fixed number of cycles. It then waits for the converter's busy line to rise and fall again, opens a serial frame with an active-low chip-select, and generates a serial clock divided down from the system clock. The two results come back MSB first.

There are two read modes, and the mode is captured when the start request is accepted. In dual-lane mode each result arrives on its own data line, and both are shifted in at the same time. In single-lane mode the frame is stretched so that lane A carries the channel A result followed by the channel B result. The second result always starts in slot 14 of the frame. With 12-bit results, two filler zeros sit in slots 12 and 13, and the controller skips them. Each data bit is taken a fixed settle delay after the controller drives the serial clock low. If busy does not complete within a cycle budget, the transaction ends with an error pulse and no frame.

Top module: `adc_dual_rd`

## Requirements
- R1: After reset, chip-select, the conversion strobe and the serial clock are high, valid and error are low, and both results are zero.
- R2: An accepted start holds the conversion strobe low for exactly CONV_W cycles. A start raised while a transaction is in progress is ignored, so there is one strobe per transaction.
- R3: Chip-select falls only after the synchronised busy line has been seen high and then low. It never falls while busy is high.
- R4: The serial clock is high whenever chip-select is high. It is still high in the cycle chip-select falls, and stays high for CLK_HALF cycles before its first falling edge. It produces no falling edge outside a frame.
- R5: In dual-lane mode a frame has exactly RES_W falling edges. Slot k (the low phase after falling edge k+1) holds bit RES_W-1-k of each result: lane A gives channel A and lane B gives channel B.
- R6: In single-lane mode a frame has exactly RES_W+14 falling edges. Channel A comes from lane A in slots 0..RES_W-1 and channel B from lane A in slots 14..13+RES_W. Lane B is ignored.
- R7: With RES_W=12 in single-lane mode, the bits in slots 12 and 13 are discarded. With RES_W=14 the second result follows directly after the first.
- R8: Valid is a one-cycle pulse, raised the cycle after chip-select returns high. The result outputs change only in a valid cycle.
- R9: If busy has not completed its rise and fall within BUSY_TMO cycles of the strobe ending, err_o pulses for one cycle. No frame is opened, valid stays low and the results keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a conversion and readout (taken when idle) |
| single_lane_i | input | 1 | 1: chained single-lane read on lane A; 0: dual-lane read |
| busy_i | input | 1 | Converter busy, asynchronous |
| sdata_a_i | input | 1 | Serial data lane A |
| sdata_b_i | input | 1 | Serial data lane B |
| cnvst_no | output | 1 | Conversion strobe, active low |
| cs_no | output | 1 | Chip-select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| res_a_o | output | RES_W | Channel A result |
| res_b_o | output | RES_W | Channel B result |
| valid_o | output | 1 | One-cycle pulse when new results are presented |
| err_o | output | 1 | One-cycle pulse on busy timeout |

## Verification
A converter model in the bench shifts its data on the controller's serial-clock falling edges and always chains both results. It also records whether chip-select fell while the serial clock was high. A design that gets the ignored coincident edge wrong shifts every result by one bit. In single-lane mode lane B is driven with inverted data, so a design that reads it returns corrupted channel A values. Near-boundary patterns in both widths show whether the padding was skipped or shifted in: the 12-bit channel B would come out wrong. Busy that never rises and busy that sticks high must both end in a single error pulse with the old results intact. A long but legal busy must not trip the watchdog, and a second start during a transaction must not produce a second strobe.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // slot where the chained second result begins in single-lane mode
  localparam int unsigned CHAIN_OFS = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_END
  } rd_state_e;

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/adc_rd_wdog.sv
module adc_rd_wdog #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_W    = 12,
  parameter int unsigned CONV_W   = 4,
  parameter int unsigned CLK_HALF = 3,
  parameter int unsigned SETTLE   = 1,
  parameter int unsigned SLOT_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              single_i,
  input  logic              busy_s_i,
  input  logic              wd_exp_i,
  output logic              cnvst_no,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              sample_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              single_o,
  output logic              wd_run_o,
  output logic              commit_o,
  output logic              fail_o
);

  localparam int unsigned PH_MAX = (CONV_W > CLK_HALF) ? CONV_W : CLK_HALF;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam logic [SLOT_W-1:0] LAST_DUAL   = SLOT_W'(RES_W - 1);
  localparam logic [SLOT_W-1:0] LAST_SINGLE = SLOT_W'(CHAIN_OFS + RES_W - 1);

  rd_state_e         state_q, state_d;
  logic [PH_W-1:0]   ph_q, ph_lim;
  logic [SLOT_W-1:0] slot_q, last_slot;
  logic              mode_q, fail_q, ph_end, timing, waiting;

  assign ph_lim    = (state_q == ST_CONV) ? PH_W'(CONV_W - 1) : PH_W'(CLK_HALF - 1);
  assign ph_end    = (ph_q == ph_lim);
  assign last_slot = mode_q ? LAST_SINGLE : LAST_DUAL;
  assign waiting   = (state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO);
  assign timing    = (state_q == ST_CONV) || (state_q == ST_LEAD) ||
                     (state_q == ST_LOW)  || (state_q == ST_HIGH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_CONV;
      ST_CONV:    if (ph_end) state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (wd_exp_i) state_d = ST_IDLE;
                  else if (busy_s_i) state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (wd_exp_i) state_d = ST_IDLE;
                  else if (!busy_s_i) state_d = ST_LEAD;
      ST_LEAD:    if (ph_end) state_d = ST_LOW;
      ST_LOW:     if (ph_end) state_d = ST_HIGH;
      ST_HIGH:    if (ph_end) state_d = (slot_q == last_slot) ? ST_END : ST_LOW;
      ST_END:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      slot_q  <= '0;
      mode_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fail_q  <= waiting && wd_exp_i;
      if (state_d != state_q) ph_q <= '0;
      else if (timing)        ph_q <= ph_q + 1'b1;
      if (state_q == ST_IDLE) begin
        slot_q <= '0;
        if (start_i) mode_q <= single_i;
      end else if (state_q == ST_HIGH && ph_end && slot_q != last_slot) begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign cnvst_no = (state_q != ST_CONV);
  assign cs_no    = !((state_q == ST_LEAD) || (state_q == ST_LOW) || (state_q == ST_HIGH));
  assign sclk_o   = (state_q != ST_LOW);
  assign sample_o = (state_q == ST_LOW) && (ph_q == PH_W'(SETTLE));
  assign slot_o   = slot_q;
  assign single_o = mode_q;
  assign wd_run_o = waiting;
  assign commit_o = (state_q == ST_END);
  assign fail_o   = fail_q;

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              single_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              sda_i,
  input  logic              sdb_i,
  input  logic              commit_i,
  output logic [RES_W-1:0]  res_a_o,
  output logic [RES_W-1:0]  res_b_o
);

  localparam logic [SLOT_W-1:0] A_END = SLOT_W'(RES_W);
  localparam logic [SLOT_W-1:0] B_BEG = SLOT_W'(CHAIN_OFS);

  logic [RES_W-1:0] sh_a_q, sh_b_q;
  logic             take_a, take_b, bit_b;

  // slots between A_END and B_BEG carry filler bits in single-lane mode
  assign take_a = sample_i && (slot_i < A_END);
  assign take_b = sample_i && (single_i ? (slot_i >= B_BEG) : (slot_i < A_END));
  assign bit_b  = single_i ? sda_i : sdb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_a_q  <= '0;
      sh_b_q  <= '0;
      res_a_o <= '0;
      res_b_o <= '0;
    end else begin
      if (take_a) sh_a_q <= {sh_a_q[RES_W-2:0], sda_i};
      if (take_b) sh_b_q <= {sh_b_q[RES_W-2:0], bit_b};
      if (commit_i) begin
        res_a_o <= sh_a_q;
        res_b_o <= sh_b_q;
      end
    end
  end

endmodule

// File: rtl/adc_dual_rd.sv
module adc_dual_rd
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_W       = 12,
  parameter int unsigned CONV_W      = 4,
  parameter int unsigned CLK_HALF    = 3,
  parameter int unsigned SETTLE      = 1,
  parameter int unsigned BUSY_TMO    = 4096,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             single_lane_i,
  input  logic             busy_i,
  input  logic             sdata_a_i,
  input  logic             sdata_b_i,
  output logic             cnvst_no,
  output logic             cs_no,
  output logic             sclk_o,
  output logic [RES_W-1:0] res_a_o,
  output logic [RES_W-1:0] res_b_o,
  output logic             valid_o,
  output logic             err_o
);

  localparam int unsigned FRAME_MAX = CHAIN_OFS + RES_W;
  localparam int unsigned SLOT_W    = $clog2(FRAME_MAX);

  logic              busy_s, wd_run, wd_exp, sample, commit, single_q, fail;
  logic [SLOT_W-1:0] slot;
  logic              valid_q;

  adc_rd_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (busy_i),
    .q_o   (busy_s)
  );

  adc_rd_wdog #(.LIMIT(BUSY_TMO)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (wd_run),
    .expired_o(wd_exp)
  );

  adc_rd_seq #(
    .RES_W   (RES_W),
    .CONV_W  (CONV_W),
    .CLK_HALF(CLK_HALF),
    .SETTLE  (SETTLE),
    .SLOT_W  (SLOT_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .single_i(single_lane_i),
    .busy_s_i(busy_s),
    .wd_exp_i(wd_exp),
    .cnvst_no(cnvst_no),
    .cs_no   (cs_no),
    .sclk_o  (sclk_o),
    .sample_o(sample),
    .slot_o  (slot),
    .single_o(single_q),
    .wd_run_o(wd_run),
    .commit_o(commit),
    .fail_o  (fail)
  );

  adc_rd_capture #(.RES_W(RES_W), .SLOT_W(SLOT_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample),
    .single_i(single_q),
    .slot_i  (slot),
    .sda_i   (sdata_a_i),
    .sdb_i   (sdata_b_i),
    .commit_i(commit),
    .res_a_o (res_a_o),
    .res_b_o (res_b_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= commit;
  end

  assign valid_o = valid_q;
  assign err_o   = fail;

endmodule

// File: rtl/adc_dual_rd_chk.sv
module adc_dual_rd_chk #(
  parameter int unsigned RES_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_s,
  input logic             cnvst_no,
  input logic             cs_no,
  input logic             sclk_o,
  input logic             valid_o,
  input logic             err_o,
  input logic [RES_W-1:0] res_a_o,
  input logic [RES_W-1:0] res_b_o
);

  // R4
  sclk_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  // R4
  cs_fall_sclk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> sclk_o);

  // R3
  cs_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !busy_s);

  // R2
  strobe_outside_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnvst_no) |-> cs_no);

  // R8
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  res_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_a_o) |-> valid_o);

  // R8
  res_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_b_o) |-> valid_o);

  // R9
  err_no_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!valid_o && cs_no));

  // R9
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

endmodule

bind adc_dual_rd adc_dual_rd_chk #(.RES_W(RES_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_s  (busy_s),
  .cnvst_no(cnvst_no),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o),
  .valid_o (valid_o),
  .err_o   (err_o),
  .res_a_o (res_a_o),
  .res_b_o (res_b_o)
);

// File: tb/adc_model.sv
module adc_model #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         cnvst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  input  int           busy_len,
  input  logic [1:0]   busy_mode,  // 0 normal, 1 never rises, 2 stuck high
  input  logic         corrupt_b,
  output logic         busy,
  output logic         sda,
  output logic         sdb,
  output int           falls,
  output int           stray,
  output int           cs_falls,
  output logic         lead_ok,
  output logic         cs_busy_bad
);

  initial begin
    busy = 1'b0;
  end

  function automatic logic stream(logic [W-1:0] f, logic [W-1:0] s, int i);
    if (i < W)           return f[W-1-i];
    else if (i < 14)     return 1'b0;
    else if (i < 14 + W) return s[W-1-(i-14)];
    else                 return 1'b0;
  endfunction

  always @(negedge cnvst_n) begin
    if (busy_mode != 2'd1) begin
      repeat (2) @(negedge clk);
      busy = 1'b1;
      if (busy_mode == 2'd2) begin
        while (busy_mode == 2'd2) @(negedge clk);
      end else begin
        repeat (busy_len) @(negedge clk);
      end
      busy = 1'b0;
    end
  end

  initial begin
    falls = 0;
    stray = 0;
    forever begin
      @(negedge sclk or negedge cnvst_n);
      if (!cnvst_n) falls = 0;
      else if (!cs_n) falls = falls + 1;
      else stray = stray + 1;
    end
  end

  initial begin
    cs_falls = 0;
    lead_ok = 1'b1;
    cs_busy_bad = 1'b0;
    forever begin
      @(negedge cs_n);
      cs_falls = cs_falls + 1;
      if (!sclk) lead_ok = 1'b0;
      if (busy) cs_busy_bad = 1'b1;
    end
  end

  int idx;
  always_comb begin
    idx = (falls == 0) ? 0 : falls - 1;
    sda = stream(val_a, val_b, idx);
    sdb = corrupt_b ? ~stream(val_b, val_a, idx) : stream(val_b, val_a, idx);
  end

endmodule

// File: tb/adc_dual_rd_test.sv
module adc_dual_rd_test;

  localparam int CONV_W = 4;
  localparam int TMO    = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic       st[2], sl[2], busy[2], sda[2], sdb[2];
  logic       cn[2], cs[2], sc[2], vld[2], err[2];
  logic [13:0] va[2], vb[2];
  int         blen[2];
  logic [1:0] bmode[2];
  logic       corrupt[2];
  int         falls[2], stray[2], csf[2];
  logic       lead_ok[2], cs_busy[2];
  logic [11:0] ra12, rb12;
  logic [13:0] ra14, rb14;

  adc_dual_rd #(.RES_W(12), .CONV_W(CONV_W), .CLK_HALF(3), .SETTLE(1), .BUSY_TMO(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st[0]), .single_lane_i(sl[0]), .busy_i(busy[0]),
    .sdata_a_i(sda[0]), .sdata_b_i(sdb[0]), .cnvst_no(cn[0]), .cs_no(cs[0]), .sclk_o(sc[0]),
    .res_a_o(ra12), .res_b_o(rb12), .valid_o(vld[0]), .err_o(err[0]));

  adc_dual_rd #(.RES_W(14), .CONV_W(CONV_W), .CLK_HALF(3), .SETTLE(1), .BUSY_TMO(TMO)) uut_w (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st[1]), .single_lane_i(sl[1]), .busy_i(busy[1]),
    .sdata_a_i(sda[1]), .sdata_b_i(sdb[1]), .cnvst_no(cn[1]), .cs_no(cs[1]), .sclk_o(sc[1]),
    .res_a_o(ra14), .res_b_o(rb14), .valid_o(vld[1]), .err_o(err[1]));

  adc_model #(.W(12)) m12 (
    .clk(clk), .cnvst_n(cn[0]), .cs_n(cs[0]), .sclk(sc[0]), .val_a(va[0][11:0]), .val_b(vb[0][11:0]),
    .busy_len(blen[0]), .busy_mode(bmode[0]), .corrupt_b(corrupt[0]), .busy(busy[0]),
    .sda(sda[0]), .sdb(sdb[0]), .falls(falls[0]), .stray(stray[0]), .cs_falls(csf[0]),
    .lead_ok(lead_ok[0]), .cs_busy_bad(cs_busy[0]));

  adc_model #(.W(14)) m14 (
    .clk(clk), .cnvst_n(cn[1]), .cs_n(cs[1]), .sclk(sc[1]), .val_a(va[1]), .val_b(vb[1]),
    .busy_len(blen[1]), .busy_mode(bmode[1]), .corrupt_b(corrupt[1]), .busy(busy[1]),
    .sda(sda[1]), .sdb(sdb[1]), .falls(falls[1]), .stray(stray[1]), .cs_falls(csf[1]),
    .lead_ok(lead_ok[1]), .cs_busy_bad(cs_busy[1]));

  function automatic logic [13:0] get_a(int s);
    return s != 0 ? ra14 : {2'b00, ra12};
  endfunction

  function automatic logic [13:0] get_b(int s);
    return s != 0 ? rb14 : {2'b00, rb12};
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // R1
  task automatic t_reset();
    for (int s = 0; s < 2; s++) begin
      chk("R1", "cs_no", cs[s], 1);
      chk("R1", "cnvst_no", cn[s], 1);
      chk("R1", "sclk", sc[s], 1);
      chk("R1", "valid", vld[s], 0);
      chk("R1", "err", err[s], 0);
      chk("R1", "res_a", get_a(s), 0);
      chk("R1", "res_b", get_b(s), 0);
    end
  endtask

  task automatic t_read(int s, bit single, logic [13:0] a, logic [13:0] b, bit corr,
                        int bl, bit extra_start);
    int w = (s != 0) ? 14 : 12;
    logic [13:0] mask = 14'((1 << w) - 1);
    string rq = single ? "R6" : "R5";
    int lows = 0, nfall = 0, vcnt = 0, errs = 0, stray0, i;
    logic prev_cn = 1'b1;
    bit done = 0;
    va[s] = a & mask; vb[s] = b & mask; corrupt[s] = corr; blen[s] = bl; bmode[s] = 2'd0;
    stray0 = stray[s];
    @(negedge clk); st[s] = 1'b1; sl[s] = single;
    @(negedge clk); st[s] = 1'b0;
    for (i = 0; i < 3000 && !done; i++) begin
      if (!cn[s]) lows++;
      if (prev_cn && !cn[s]) nfall++;
      prev_cn = cn[s];
      if (err[s]) errs++;
      st[s] = (extra_start && i == 30);
      if (vld[s]) done = 1;
      else @(negedge clk);
    end
    st[s] = 1'b0;
    chk("R8", "valid seen", done, 1);
    chk(rq, "res_a", get_a(s), a & mask);
    chk(single ? "R7" : "R5", "res_b", get_b(s), b & mask);
    chk(rq, "falling edges", falls[s], single ? w + 14 : w);
    chk("R2", "strobe low cycles", lows, CONV_W);
    chk("R4", "sclk high at cs fall", lead_ok[s], 1);
    chk("R3", "cs fell while busy", cs_busy[s], 0);
    chk("R9", "no error on good busy", errs, 0);
    @(negedge clk);
    chk("R8", "valid width", vld[s], 0);
    for (int k = 0; k < 12; k++) begin
      if (prev_cn && !cn[s]) nfall++;
      prev_cn = cn[s];
      if (vld[s]) vcnt++;
      @(negedge clk);
    end
    chk("R2", "one strobe per transaction", nfall, 1);
    chk("R8", "no extra valid", vcnt, 0);
    chk("R8", "res_a held", get_a(s), a & mask);
    chk("R4", "no edge outside frame", stray[s] - stray0, 0);
  endtask

  // R9
  task automatic t_timeout(int s, logic [1:0] mode);
    logic [13:0] ha = get_a(s), hb = get_b(s);
    int cs0 = csf[s], at = -1, ecnt = 0, vcnt = 0;
    bmode[s] = mode;
    @(negedge clk); st[s] = 1'b1;
    @(negedge clk); st[s] = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (err[s]) begin
        ecnt++;
        if (at < 0) at = i;
      end
      if (vld[s]) vcnt++;
      @(negedge clk);
    end
    chk("R9", "err pulse count", ecnt, 1);
    chk("R9", "err after budget", (at >= TMO && at <= TMO + CONV_W + 8), 1);
    chk("R9", "no valid", vcnt, 0);
    chk("R9", "no frame", csf[s] - cs0, 0);
    chk("R9", "res_a kept", get_a(s), ha);
    chk("R9", "res_b kept", get_b(s), hb);
    bmode[s] = 2'd0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      st[s] = 0; sl[s] = 0; va[s] = 0; vb[s] = 0; blen[s] = 20; bmode[s] = 0; corrupt[s] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(0, 0, 14'h0A5C, 14'h03F1, 0, 20, 0);
    t_read(0, 0, 14'h0FFF, 14'h0000, 0, 5, 0);
    t_read(0, 1, 14'h09B3, 14'h04E7, 1, 20, 0);
    t_read(0, 1, 14'h0001, 14'h0800, 1, 12, 0);
    t_read(1, 0, 14'h2AC5, 14'h1337, 0, 20, 0);
    t_read(1, 1, 14'h3FFF, 14'h2001, 1, 20, 0);
    t_read(1, 1, 14'h0002, 14'h3FFE, 1, 8, 0);
    t_read(0, 0, 14'h0123, 14'h0FED, 0, 55, 1);
    t_timeout(0, 2'd1);
    t_timeout(1, 2'd2);
    t_read(0, 1, 14'h0C3A, 14'h05A5, 1, 20, 0);
    t_read(1, 0, 14'h1E0F, 14'h21F0, 0, 20, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

endmodule